// File: doc/BRIEF.md
# Display Sync Level Regenerator for Pulse-Timed DSI Video

This block turns the one-cycle short-packet events from a DSI packet decoder into the steady VSYNC and HSYNC levels that a parallel display interface expects. It targets non-burst video streams in which the host sends explicit start and end packets for each sync pulse. The decoder reports each short packet as a single-cycle strobe in the byte clock domain, together with its data type and virtual channel. The block keeps the sync levels in that domain and then passes them through synchronizer flops into the pixel clock domain, where the display timing is used.

After any reset, the link may still carry the tail of a frame that was in flight while the PLL was locking. The block therefore refuses every packet until it sees the first vertical-start packet. Only that packet opens the frame and arms the block. Both clock domains are held in reset while the serializer reports that it is not ready. Reset is applied at once and is released on each domain's own clock.

Top module: `dsi_sync_regen`

## Requirements
- R1: An accepted vertical-start packet (data type 0x01) on the selected virtual channel drives both vsync and hsync high.
- R2: An accepted vertical-end packet (data type 0x11) drives vsync low and drives hsync high.
- R3: An accepted horizontal-start packet (data type 0x21) drives hsync high and leaves vsync unchanged.
- R4: An accepted horizontal-end packet (data type 0x31) drives hsync low and leaves vsync unchanged.
- R5: After a reset, every packet is ignored until a vertical-start packet on the selected channel arrives. That packet is itself accepted.
- R6: A packet on another virtual channel, or one with any other data type, leaves both outputs unchanged.
- R7: A level change reaches the outputs through two pixel-clock flops. It is not visible one time unit after the byte edge that captured the packet, and it is visible after three pixel clock edges.
- R8: While ser_rdy is low, both outputs are low. When ser_rdy returns high, the block must see a new vertical-start packet before it accepts any other packet.
- R9: Driving rst_n low forces both outputs low at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| byte_clk | input | 1 | Byte clock of the packet decoder |
| pix_clk | input | 1 | Pixel clock of the display side |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_rdy | input | 1 | Serializer ready; low holds both domains in reset |
| sp_en | input | 1 | One-cycle short-packet strobe (byte_clk) |
| sp_dt | input | DT_W | Data type of the strobed packet |
| sp_vc | input | 2 | Virtual channel of the strobed packet |
| vsync | output | 1 | Vertical sync level (pix_clk) |
| hsync | output | 1 | Horizontal sync level (pix_clk) |

## Verification
If the armed flag is wrong, whole bursts of packets show up at the ports: horizontal starts either raise hsync before any frame has begun, or they are dropped after one has. A wrong sync level stays wrong until the next packet of the same kind, and it shows up no more than three pixel clocks after the packet. The bench therefore checks both outputs after every packet, in random streams that mix foreign channels and unknown codes. It also checks the outputs right after the capturing edge, which catches a path that skips the synchronizer.

// File: rtl/dsi_sync_regen.sv
module dsi_sync_regen #(
  parameter logic [1:0] VC_SEL = 2'd0,
  parameter int DT_W = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic            byte_clk,
  input  logic            pix_clk,
  input  logic            rst_n,
  input  logic            ser_rdy,
  input  logic            sp_en,
  input  logic [DT_W-1:0] sp_dt,
  input  logic [1:0]      sp_vc,
  output logic            vsync,
  output logic            hsync
);
  localparam logic [DT_W-1:0] DT_VSS = DT_W'(8'h01);
  localparam logic [DT_W-1:0] DT_VSE = DT_W'(8'h11);
  localparam logic [DT_W-1:0] DT_HSS = DT_W'(8'h21);
  localparam logic [DT_W-1:0] DT_HSE = DT_W'(8'h31);

  logic arst_n;
  assign arst_n = rst_n & ser_rdy;

  logic [1:0] brst_sr, prst_sr;
  always_ff @(posedge byte_clk or negedge arst_n)
    if (!arst_n) brst_sr <= '0;
    else         brst_sr <= {brst_sr[0], 1'b1};
  always_ff @(posedge pix_clk or negedge arst_n)
    if (!arst_n) prst_sr <= '0;
    else         prst_sr <= {prst_sr[0], 1'b1};

  logic brst_n, prst_n;
  assign brst_n = brst_sr[1];
  assign prst_n = prst_sr[1];

  logic hit, is_vss, is_vse, is_hss, is_hse, take;
  assign hit    = sp_en && (sp_vc == VC_SEL);
  assign is_vss = sp_dt == DT_VSS;
  assign is_vse = sp_dt == DT_VSE;
  assign is_hss = sp_dt == DT_HSS;
  assign is_hse = sp_dt == DT_HSE;

  logic armed, vs_q, hs_q;
  assign take = hit && (armed || is_vss);

  always_ff @(posedge byte_clk or negedge brst_n) begin
    if (!brst_n) begin
      armed <= 1'b0;
      vs_q  <= 1'b0;
      hs_q  <= 1'b0;
    end else begin
      if (hit && is_vss) armed <= 1'b1;
      if (take) begin
        if (is_vss) begin vs_q <= 1'b1; hs_q <= 1'b1; end
        if (is_vse) begin vs_q <= 1'b0; hs_q <= 1'b1; end
        if (is_hss) hs_q <= 1'b1;
        if (is_hse) hs_q <= 1'b0;
      end
    end
  end

  logic [SYNC_STAGES-1:0] vs_sr, hs_sr;
  always_ff @(posedge pix_clk or negedge prst_n) begin
    if (!prst_n) begin
      vs_sr <= '0;
      hs_sr <= '0;
    end else begin
      vs_sr <= {vs_sr[SYNC_STAGES-2:0], vs_q};
      hs_sr <= {hs_sr[SYNC_STAGES-2:0], hs_q};
    end
  end
  assign vsync = vs_sr[SYNC_STAGES-1];
  assign hsync = hs_sr[SYNC_STAGES-1];

  // R1
  vs_start_chk: assert property (@(posedge byte_clk) disable iff (!brst_n)
    (hit && is_vss) |=> (vs_q && hs_q));
  // R2
  vs_end_chk: assert property (@(posedge byte_clk) disable iff (!brst_n)
    (take && is_vse) |=> (!vs_q && hs_q));
  // R4
  hs_end_chk: assert property (@(posedge byte_clk) disable iff (!brst_n)
    (take && is_hse) |=> (!hs_q && $stable(vs_q)));
  // R5
  gate_chk: assert property (@(posedge byte_clk) disable iff (!brst_n)
    !armed |-> (!vs_q && !hs_q));
  // R5
  arm_chk: assert property (@(posedge byte_clk) disable iff (!brst_n)
    $rose(armed) |-> $past(hit && is_vss));
  // R6
  foreign_chk: assert property (@(posedge byte_clk) disable iff (!brst_n)
    (!hit) |=> ($stable(vs_q) && $stable(hs_q)));
  generate if (SYNC_STAGES == 2) begin : g_lat
    // R7
    vs_lat_chk: assert property (@(posedge pix_clk) disable iff (!prst_n)
      $rose(vsync) |-> $past(vs_q, 2));
    // R7
    hs_lat_chk: assert property (@(posedge pix_clk) disable iff (!prst_n)
      $rose(hsync) |-> $past(hs_q, 2));
  end endgenerate
endmodule

// File: tb/dsi_sync_regen_bench.sv
module dsi_sync_regen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_PERIOD = 14;
  localparam logic [1:0] VC = 2'd2;

  logic byte_clk = 0, pix_clk = 0, rst_n = 0, ser_rdy = 0;
  logic sp_en = 0;
  logic [5:0] sp_dt = '0;
  logic [1:0] sp_vc = '0;
  logic vsync, hsync;

  always #(CLK_PERIOD/2) byte_clk = ~byte_clk;
  always #(PIX_PERIOD/2) pix_clk = ~pix_clk;

  dsi_sync_regen #(.VC_SEL(VC), .DT_W(6), .SYNC_STAGES(2)) u_dsi_sync_regen (
    .byte_clk(byte_clk), .pix_clk(pix_clk), .rst_n(rst_n), .ser_rdy(ser_rdy),
    .sp_en(sp_en), .sp_dt(sp_dt), .sp_vc(sp_vc), .vsync(vsync), .hsync(hsync));

  int checks = 0, errors = 0;
  bit m_arm = 0, m_vs = 0, m_hs = 0;

  task automatic chk(input string req, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit [2:0] next_state(input bit [2:0] s, input logic [5:0] dt,
                                          input logic [1:0] vc);
    bit a, v, h;
    {a, v, h} = s;
    if (vc != VC) return s;
    if (!a && dt != 6'h01) return s;
    case (dt)
      6'h01: begin a = 1; v = 1; h = 1; end
      6'h11: begin v = 0; h = 1; end
      6'h21: h = 1;
      6'h31: h = 0;
      default: ;
    endcase
    return {a, v, h};
  endfunction

  task automatic send(input logic [5:0] dt, input logic [1:0] vc, input string req);
    bit ov, oh;
    @(negedge byte_clk);
    sp_en = 1; sp_dt = dt; sp_vc = vc;
    ov = m_vs; oh = m_hs;
    @(posedge byte_clk);
    #1;
    // R7: not yet through the synchronizer
    chk("R7 early vsync", vsync, ov);
    chk("R7 early hsync", hsync, oh);
    @(negedge byte_clk);
    sp_en = 0;
    {m_arm, m_vs, m_hs} = next_state({m_arm, m_vs, m_hs}, dt, vc);
    repeat (3) @(posedge pix_clk);
    #1;
    chk({req, " vsync"}, vsync, m_vs);
    chk({req, " hsync"}, hsync, m_hs);
  endtask

  task automatic settle();
    repeat (4) @(posedge byte_clk);
    repeat (4) @(posedge pix_clk);
    #1;
  endtask

  bit done = 0;
  initial begin
    #(PIX_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] codes [4];
    codes[0] = 6'h01; codes[1] = 6'h11; codes[2] = 6'h21; codes[3] = 6'h31;
    void'($urandom(32'd4242));
    #3;
    ser_rdy = 1;
    #20 rst_n = 1;
    settle();
    chk("R9 reset vsync", vsync, 0);
    chk("R9 reset hsync", hsync, 0);

    // R5: gated before first frame start
    send(6'h21, VC, "R5 hs-start before arm");
    send(6'h11, VC, "R5 vs-end before arm");
    send(6'h01, 2'd1, "R6 vs-start foreign vc");
    send(6'h01, VC, "R1 vs-start arms");
    send(6'h31, VC, "R4 hs-end");
    send(6'h21, VC, "R3 hs-start");
    send(6'h31, VC, "R4 hs-end again");
    send(6'h11, VC, "R2 vs-end");
    send(6'h31, VC, "R4 hs-end after vs-end");
    send(6'h21, 2'd3, "R6 foreign hs-start");
    send(6'h05, VC, "R6 unknown code");
    send(6'h01, VC, "R1 second frame");

    // R9: asynchronous reset mid-frame
    @(negedge byte_clk); #2;
    rst_n = 0; #1;
    chk("R9 async vsync", vsync, 0);
    chk("R9 async hsync", hsync, 0);
    {m_arm, m_vs, m_hs} = 3'b000;
    #20 rst_n = 1;
    settle();
    send(6'h21, VC, "R5 gated after reset");
    send(6'h01, VC, "R1 rearm after reset");

    // R8: serializer not ready
    @(negedge pix_clk); #2;
    ser_rdy = 0; #1;
    chk("R8 not-ready vsync", vsync, 0);
    chk("R8 not-ready hsync", hsync, 0);
    {m_arm, m_vs, m_hs} = 3'b000;
    #30 ser_rdy = 1;
    settle();
    send(6'h21, VC, "R8 gated after ready");
    send(6'h01, VC, "R8 rearm after ready");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [5:0] dt;
      logic [1:0] vc;
      int r;
      r = $urandom_range(0, 9);
      dt = (r < 8) ? codes[r % 4] : 6'($urandom);
      vc = ($urandom_range(0, 9) < 7) ? VC : 2'($urandom);
      send(dt, vc, "R6 random stream");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule